// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

The block gathers interrupt events from a set of on-chip sources and turns each one into a four-word interrupt vector. It writes that vector into a circular buffer in system memory through a simple word-wide write-request port. Each source has a single pending slot. A round-robin arbiter picks the next slot to serve, and a small write engine issues the four words of the vector one after another. The engine moves the write pointer forward only after the last word has been accepted.

The host programs the block through a small register file. The registers set the ring base, the ring size, the read pointer, the writeback address and the enable bits. The block raises a level interrupt while unread vectors are in the ring or an overflow is pending. With overflow detection on, a vector that fills the ring sets a sticky flag in the write-pointer word, and the engine keeps writing. With writeback on, the engine stores the updated write-pointer word, flag included, at a programmable memory address after every vector.

Top module: `ivring_writer`

## Requirements
- R1: Each vector is four 32-bit words with the following layout, and all unlisted bits are zero.
  - Word 0 holds the source ID in bits [7:0].
  - Word 1 holds the 28-bit source data in bits [27:0].
  - Word 2 holds the ring ID in [7:0], the VM ID in [15:8] and the PASID in [31:16].
  - Word 3 is all zero.
- R2: The words of a vector are issued in order 0 to 3. Word k goes to byte address {BASE,8'h00} + wptr + 4k. Each request holds its address and data stable until `mem_ack` is sampled high.
- R3: The write pointer counts bytes. It advances by 16 at the clock edge that accepts word 3, and it wraps modulo the ring length of 4<<S bytes. S is CTRL[8:4], clamped to the range 2 to 14.
- R4: `host_irq` is high exactly when CTRL[1] is set and either the read pointer (masked to the ring) differs from the write pointer or the overflow flag is set.
- R5: Overflow detection is enabled by CTRL[2]. With it on, a vector whose pointer update makes the write pointer equal to the read pointer sets the flag, which appears at WPTR bit 0, and writing continues. The flag stays set until CTRL is written with bit 31 high; a set in the same cycle wins. With detection off, the flag never sets.
- R6: Writeback is enabled by CTRL[3]. With it on, every vector is followed by a fifth write of the WPTR word to byte address {WBHI[7:0], WBLO[31:2], 2'b00}. With it off, no fifth write occurs. WBHI keeps only 8 bits.
- R7: Each source has one pending slot, and `src_ready` is low while that slot is full. Slots are served round-robin, starting after the last source served; source 0 is served first after reset.
- R8: A vector starts only while both CTRL[0] (ring enable) and CTRL[1] (interrupt enable) are set. Writes to WPTR take effect only while CTRL[0] is clear; they load the pointer and clear the flag.
- R9: STATUS bit 0 (busy) is high while any slot is pending or a vector or writeback is in flight.
- R10: The register file is laid out as follows, and all registers reset to zero.

| Index | Name | Contents |
|---|---|---|
| 0 | CTRL | Control fields; bit 31 reads as 0 |
| 1 | BASE | Address bits [39:8] |
| 2 | RPTR | Byte read pointer; low 4 bits forced to 0 |
| 3 | WPTR | Write pointer, read-only while enabled |
| 4 | WBLO | Writeback address bits [31:2] |
| 5 | WBHI | Writeback address bits [39:32] |
| 6 | STATUS | Bit 1 is pointers-equal, bit 0 is busy |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | NUM_SRC | Event request per source |
| src_event | input | NUM_SRC*68 | Per-source event: [67:52] PASID, [51:44] VM ID, [43:36] ring ID, [35:8] data, [7:0] source ID |
| src_ready | output | NUM_SRC | Pending slot of the source is empty |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory write request |
| mem_ack | input | 1 | Memory write accepted |
| mem_addr | output | 40 | Byte address of the word |
| mem_data | output | 32 | Word to write |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The bench goes after the overflow edge, where the fourth vector into a four-vector ring lands the write pointer on the read pointer. A design that compared the pointers before the update would flag one vector too early, and one that stalled would stop the stream. The bench also has all sources fire in the same cycle right after a single-source vector. A wrong rotation start would show up as a mismatched source ID in word 0. Acks are delayed at random, so an engine that moved its pointer on word 0, or changed its address before the ack, would write to the wrong addresses. The bench also writes the pointers while the ring is disabled and while it is enabled, and shrinks the ring to a single vector. Each of these exposes a missed gate or a wrong wrap mask.

// File: rtl/ivr_pkg.sv
// Shared types and constants of the interrupt vector ring writer.
package ivr_pkg;

    // One interrupt event as supplied by a source (68 bits, MSB first).
    typedef struct packed {
        logic [15:0] pasid;
        logic [7:0]  vm_id;
        logic [7:0]  ring_id;
        logic [27:0] data;
        logic [7:0]  src_id;
    } ivr_event_t;

    localparam int EVT_W  = $bits(ivr_event_t);
    localparam int ADDR_W = 40;

    // Write engine states: four vector words, then optional writeback.
    typedef enum logic [2:0] {
        ENG_IDLE = 3'd0,
        ENG_W0   = 3'd1,
        ENG_W1   = 3'd2,
        ENG_W2   = 3'd3,
        ENG_W3   = 3'd4,
        ENG_WB   = 3'd5
    } eng_state_t;

    // Register indices.
    localparam logic [2:0] RIDX_CTRL   = 3'd0;
    localparam logic [2:0] RIDX_BASE   = 3'd1;
    localparam logic [2:0] RIDX_RPTR   = 3'd2;
    localparam logic [2:0] RIDX_WPTR   = 3'd3;
    localparam logic [2:0] RIDX_WBLO   = 3'd4;
    localparam logic [2:0] RIDX_WBHI   = 3'd5;
    localparam logic [2:0] RIDX_STATUS = 3'd6;

endpackage

// File: rtl/ivr_arbiter.sv
// Per-source pending slots with a round-robin grant.
// Assumes: a slot is filled only when empty; take clears the granted slot.
module ivr_arbiter
    import ivr_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_valid,
    input  logic [NUM_SRC*EVT_W-1:0] src_event,
    output logic [NUM_SRC-1:0]       src_ready,
    input  logic                     take,
    output logic                     gnt_valid,
    output ivr_event_t               gnt_event,
    output logic                     any_pending
);
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] slot_v;
    ivr_event_t         slot_q [NUM_SRC];
    logic [IDXW-1:0]    last_q;
    logic [IDXW-1:0]    gnt_idx;

    // Search the slots in rotating order, starting after the last one served.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= NUM_SRC; k++) begin
            int c;
            c = int'(last_q) + k;
            if (c >= NUM_SRC) c = c - NUM_SRC;
            if (!gnt_valid && slot_v[c]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDXW'(c);
            end
        end
    end

    assign gnt_event   = slot_q[gnt_idx];
    assign src_ready   = ~slot_v;
    assign any_pending = |slot_v;

    // One pending slot per source: fill when empty, clear on grant.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[g] <= 1'b0;
                slot_q[g] <= '0;
            end else if (take && gnt_idx == IDXW'(g)) begin
                slot_v[g] <= 1'b0;
            end else if (src_valid[g] && !slot_v[g]) begin
                slot_v[g] <= 1'b1;
                slot_q[g] <= src_event[g*EVT_W +: EVT_W];
            end
        end
    end

    // Remember the last source served for the rotation.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= IDXW'(NUM_SRC - 1);
        else if (take) last_q <= gnt_idx;
    end

endmodule

// File: rtl/ivr_regs.sv
// Host register file: control, ring base, read pointer, writeback address.
// Assumes: write-pointer state lives in the engine; this block only
// forwards load and clear pulses and gates the load on ring disable.
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2 = 14,
    parameter int PTRW     = MAX_LOG2 + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       wptr_word,
    input  logic              busy,
    input  logic              ptr_eq,
    output logic              ring_en,
    output logic              intr_en,
    output logic              ovf_en,
    output logic              wb_en,
    output logic [PTRW-1:0]   ptr_mask,
    output logic [31:0]       base,
    output logic [PTRW-1:0]   rptr,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              wptr_load,
    output logic [PTRW-1:0]   wptr_load_val,
    output logic              ovf_clr
);
    logic [4:0]  size_q;
    logic [4:0]  size_eff;
    logic [29:0] wblo_q;
    logic [7:0]  wbhi_q;

    // Register writes from the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_en <= 1'b0;
            intr_en <= 1'b0;
            ovf_en  <= 1'b0;
            wb_en   <= 1'b0;
            size_q  <= '0;
            base    <= '0;
            rptr    <= '0;
            wblo_q  <= '0;
            wbhi_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RIDX_CTRL: begin
                    ring_en <= reg_wdata[0];
                    intr_en <= reg_wdata[1];
                    ovf_en  <= reg_wdata[2];
                    wb_en   <= reg_wdata[3];
                    size_q  <= reg_wdata[8:4];
                end
                RIDX_BASE: base   <= reg_wdata;
                RIDX_RPTR: rptr   <= {reg_wdata[PTRW-1:4], 4'b0000};
                RIDX_WBLO: wblo_q <= reg_wdata[31:2];
                RIDX_WBHI: wbhi_q <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    // Clamp the size field and derive the byte wrap mask.
    always_comb begin
        if (size_q < 5'd2)                 size_eff = 5'd2;
        else if (size_q > 5'(MAX_LOG2))    size_eff = 5'(MAX_LOG2);
        else                               size_eff = size_q;
        ptr_mask = ~({PTRW{1'b1}} << ({1'b0, size_eff} + 6'd2));
    end

    assign wb_addr       = {wbhi_q, wblo_q, 2'b00};
    assign wptr_load     = reg_we && reg_addr == RIDX_WPTR && !ring_en;
    assign wptr_load_val = {reg_wdata[PTRW-1:4], 4'b0000};
    assign ovf_clr       = reg_we && reg_addr == RIDX_CTRL && reg_wdata[31];

    // Read-back multiplexer.
    always_comb begin
        case (reg_addr)
            RIDX_CTRL:   reg_rdata = {23'b0, size_q, wb_en, ovf_en, intr_en, ring_en};
            RIDX_BASE:   reg_rdata = base;
            RIDX_RPTR:   reg_rdata = 32'(rptr);
            RIDX_WPTR:   reg_rdata = wptr_word;
            RIDX_WBLO:   reg_rdata = {wblo_q, 2'b00};
            RIDX_WBHI:   reg_rdata = {24'b0, wbhi_q};
            RIDX_STATUS: reg_rdata = {30'b0, ptr_eq, busy};
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ivr_engine.sv
// Vector write engine: issues four word writes per vector, then updates the
// write pointer and overflow flag, then optionally writes the pointer back.
// Assumes: mem_req is a function of state only; the host does not load the
// pointer while a vector is in flight.
module ivr_engine
    import ivr_pkg::*;
#(
    parameter int PTRW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_go,
    input  logic              ovf_en,
    input  logic              wb_en,
    input  logic [PTRW-1:0]   ptr_mask,
    input  logic [PTRW-1:0]   rptr,
    input  logic [31:0]       base,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic              gnt_valid,
    input  ivr_event_t        gnt_event,
    input  logic              wptr_load,
    input  logic [PTRW-1:0]   wptr_load_val,
    input  logic              ovf_clr,
    input  logic              mem_ack,
    output logic              take,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data,
    output logic [PTRW-1:0]   wptr,
    output logic              ovf_flag,
    output logic [31:0]       wptr_word,
    output logic              busy
);
    eng_state_t  state_q;
    ivr_event_t  vec_q;
    logic [1:0]  word_idx;
    logic [PTRW-1:0] wptr_nxt;
    logic        last_word_done;
    logic        ovf_set;
    logic [ADDR_W-1:0] ring_addr;

    assign take           = (state_q == ENG_IDLE) && ring_go && gnt_valid;
    assign mem_req        = (state_q != ENG_IDLE);
    assign busy           = mem_req;
    assign last_word_done = (state_q == ENG_W3) && mem_ack;
    assign wptr_nxt       = (wptr + PTRW'(16)) & ptr_mask;
    assign ovf_set        = last_word_done && ovf_en && (wptr_nxt == (rptr & ptr_mask));
    assign wptr_word      = 32'(wptr) | {31'b0, ovf_flag};

    // Word index within the vector from the engine state.
    always_comb begin
        case (state_q)
            ENG_W1:  word_idx = 2'd1;
            ENG_W2:  word_idx = 2'd2;
            ENG_W3:  word_idx = 2'd3;
            default: word_idx = 2'd0;
        endcase
    end

    assign ring_addr = {base, 8'h00} + ADDR_W'(wptr) + ADDR_W'({word_idx, 2'b00});
    assign mem_addr  = (state_q == ENG_WB) ? wb_addr : ring_addr;

    // Word contents from the latched event.
    always_comb begin
        case (state_q)
            ENG_W0:  mem_data = {24'b0, vec_q.src_id};
            ENG_W1:  mem_data = {4'b0, vec_q.data};
            ENG_W2:  mem_data = {vec_q.pasid, vec_q.vm_id, vec_q.ring_id};
            ENG_WB:  mem_data = wptr_word;
            default: mem_data = '0;
        endcase
    end

    // State sequencing and event capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            vec_q   <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: if (take) begin
                    state_q <= ENG_W0;
                    vec_q   <= gnt_event;
                end
                ENG_W0: if (mem_ack) state_q <= ENG_W1;
                ENG_W1: if (mem_ack) state_q <= ENG_W2;
                ENG_W2: if (mem_ack) state_q <= ENG_W3;
                ENG_W3: if (mem_ack) state_q <= wb_en ? ENG_WB : ENG_IDLE;
                ENG_WB: if (mem_ack) state_q <= ENG_IDLE;
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // Write pointer: host load while disabled, else advance after word 3.
    always_ff @(posedge clk) begin
        if (!rst_n)              wptr <= '0;
        else if (wptr_load)      wptr <= wptr_load_val;
        else if (last_word_done) wptr <= wptr_nxt;
    end

    // Sticky overflow flag: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ovf_flag <= 1'b0;
        else if (ovf_set)              ovf_flag <= 1'b1;
        else if (ovf_clr || wptr_load) ovf_flag <= 1'b0;
    end

endmodule

// File: rtl/ivring_writer.sv
// Top of the interrupt vector ring writer: arbiter, register file, engine.
// Assumes: single clock, synchronous active-low reset, memory port accepts
// one word per cycle when mem_ack is high.
module ivring_writer
    import ivr_pkg::*;
#(
    parameter int NUM_SRC  = 4,
    parameter int MAX_LOG2 = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_valid,
    input  logic [NUM_SRC*68-1:0]    src_event,
    output logic [NUM_SRC-1:0]       src_ready,
    input  logic                     reg_we,
    input  logic [2:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic                     mem_req,
    input  logic                     mem_ack,
    output logic [39:0]              mem_addr,
    output logic [31:0]              mem_data,
    output logic                     host_irq
);
    localparam int PTRW = MAX_LOG2 + 2;

    logic              ring_en, intr_en, ovf_en, wb_en;
    logic [PTRW-1:0]   ptr_mask, rptr, wptr, wptr_load_val;
    logic [31:0]       base, wptr_word;
    logic [ADDR_W-1:0] wb_addr;
    logic              wptr_load, ovf_clr, ovf_flag;
    logic              take, gnt_valid, any_pending, eng_busy, busy_any, ptr_eq;
    ivr_event_t        gnt_event;

    ivr_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_event(src_event), .src_ready(src_ready),
        .take(take), .gnt_valid(gnt_valid), .gnt_event(gnt_event),
        .any_pending(any_pending)
    );

    ivr_regs #(.MAX_LOG2(MAX_LOG2), .PTRW(PTRW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wptr_word(wptr_word), .busy(busy_any),
        .ptr_eq(ptr_eq), .ring_en(ring_en), .intr_en(intr_en),
        .ovf_en(ovf_en), .wb_en(wb_en), .ptr_mask(ptr_mask), .base(base),
        .rptr(rptr), .wb_addr(wb_addr), .wptr_load(wptr_load),
        .wptr_load_val(wptr_load_val), .ovf_clr(ovf_clr)
    );

    ivr_engine #(.PTRW(PTRW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .ring_go(ring_en && intr_en), .ovf_en(ovf_en), .wb_en(wb_en),
        .ptr_mask(ptr_mask), .rptr(rptr), .base(base), .wb_addr(wb_addr),
        .gnt_valid(gnt_valid), .gnt_event(gnt_event),
        .wptr_load(wptr_load), .wptr_load_val(wptr_load_val),
        .ovf_clr(ovf_clr), .mem_ack(mem_ack), .take(take),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .wptr(wptr), .ovf_flag(ovf_flag), .wptr_word(wptr_word),
        .busy(eng_busy)
    );

    assign ptr_eq   = ((rptr & ptr_mask) == wptr);
    assign busy_any = eng_busy || any_pending;
    assign host_irq = intr_en && (!ptr_eq || ovf_flag);

endmodule

// File: rtl/ivr_checker.sv
// Protocol and state properties of the ring writer, bound into the top.
module ivr_checker #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_valid,
    input logic [NUM_SRC-1:0] src_ready,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [39:0]        mem_addr,
    input logic [31:0]        mem_data,
    input logic               busy,
    input logic               ovf_flag,
    input logic               ovf_clr,
    input logic               wptr_load,
    input logic               ring_en,
    input logic               intr_en
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr && !wptr_load |=> ovf_flag);

    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(ring_en && intr_en));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // R7
        slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            src_valid[g] && src_ready[g] |=> !src_ready[g]);
    end
endmodule

bind ivring_writer ivr_checker #(.NUM_SRC(NUM_SRC)) u_ivr_chk (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy_any), .ovf_flag(ovf_flag),
    .ovf_clr(ovf_clr), .wptr_load(wptr_load), .ring_en(ring_en),
    .intr_en(intr_en)
);

// File: tb/tb_ivring_writer.sv
module tb_ivring_writer;
    localparam int CLK_P = 10;
    localparam int NS    = 4;
    localparam int EW    = 68;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     src_valid = '0;
    logic [NS*EW-1:0]  src_event = '0;
    logic [NS-1:0]     src_ready;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mem_req;
    logic              mem_ack = 1'b1;
    logic [39:0]       mem_addr;
    logic [31:0]       mem_data;
    logic              host_irq;

    int n_tests = 0;
    int n_fail  = 0;

    ivring_writer dut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_event(src_event),
        .src_ready(src_ready), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_data(mem_data),
        .host_irq(host_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model state.
    bit          m_sv [NS];
    logic [67:0] m_slot [NS];
    int          m_last;
    int          m_state;        // 0 idle, 1..4 word, 5 writeback
    logic [67:0] m_vec;
    int          m_wptr, m_rptr, m_size;
    bit          m_flag, m_ring, m_intr, m_ovf, m_wb;
    logic [31:0] m_base, m_wblo;
    logic [7:0]  m_wbhi;

    bit          ack_rand = 1'b0;
    logic [15:0] ack_lfsr = 16'hACE1;
    logic [31:0] rng = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int mmask();
        int s;
        s = m_size < 2 ? 2 : (m_size > 14 ? 14 : m_size);
        return (4 << s) - 1;
    endfunction

    function automatic logic [67:0] mk_event(input int s, input int n);
        logic [15:0] pasid; logic [7:0] vm; logic [7:0] rid; logic [27:0] d; logic [7:0] sid;
        pasid = 16'hA000 + 16'(n);
        vm    = 8'(n) ^ 8'h5A;
        rid   = 8'(s);
        d     = 28'h1234567 + 28'(n * 97);
        sid   = 8'h10 + 8'(s);
        return {pasid, vm, rid, d, sid};
    endfunction

    // Ack pattern: always accept or pseudo-random stalls.
    always @(negedge clk) begin
        ack_lfsr <= {ack_lfsr[14:0], ack_lfsr[15] ^ ack_lfsr[13] ^ ack_lfsr[12] ^ ack_lfsr[10]};
        mem_ack  <= ack_rand ? (ack_lfsr[0] | ack_lfsr[3]) : 1'b1;
    end

    // Cycle-by-cycle comparison just before each rising edge, then model step.
    always begin
        @(negedge clk);
        #(CLK_P/2 - 1);
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin m_sv[s] = 0; m_slot[s] = '0; end
            m_last = NS - 1; m_state = 0; m_vec = '0; m_wptr = 0; m_rptr = 0;
            m_size = 0; m_flag = 0; m_ring = 0; m_intr = 0; m_ovf = 0; m_wb = 0;
            m_base = '0; m_wblo = '0; m_wbhi = '0;
        end else begin
            bit sv_old [NS];
            bit irq_exp, set_now;
            logic [39:0] e_addr;
            logic [31:0] e_data;
            for (int s = 0; s < NS; s++)
                check(src_ready[s] == !m_sv[s], "R7 src_ready", 64'(src_ready[s]), 64'(!m_sv[s]));
            check(mem_req == (m_state != 0), "R2 mem_req", 64'(mem_req), 64'(m_state != 0));
            irq_exp = m_intr && (((m_rptr & mmask()) != m_wptr) || m_flag);
            check(host_irq == irq_exp, "R4 host_irq", 64'(host_irq), 64'(irq_exp));
            if (m_state >= 1 && m_state <= 4) begin
                e_addr = {m_base, 8'h00} + 40'(m_wptr) + 40'((m_state - 1) * 4);
                case (m_state)
                    1: e_data = {24'b0, m_vec[7:0]};
                    2: e_data = {4'b0, m_vec[35:8]};
                    3: e_data = {m_vec[67:52], m_vec[51:44], m_vec[43:36]};
                    default: e_data = '0;
                endcase
                check(mem_addr == e_addr, "R2 word address", 64'(mem_addr), 64'(e_addr));
                check(mem_data == e_data, "R1 word data", 64'(mem_data), 64'(e_data));
            end else if (m_state == 5) begin
                e_addr = {m_wbhi, m_wblo[31:2], 2'b00};
                e_data = 32'(m_wptr) | 32'(m_flag);
                check(mem_addr == e_addr, "R6 writeback address", 64'(mem_addr), 64'(e_addr));
                check(mem_data == e_data, "R6 writeback data", 64'(mem_data), 64'(e_data));
            end
            // Model next state.
            for (int s = 0; s < NS; s++) sv_old[s] = m_sv[s];
            set_now = 0;
            if (m_state >= 1 && m_state <= 4 && mem_ack) begin
                if (m_state == 4) begin
                    m_wptr = (m_wptr + 16) & mmask();
                    if (m_ovf && m_wptr == (m_rptr & mmask())) begin m_flag = 1; set_now = 1; end
                    m_state = m_wb ? 5 : 0;
                end else m_state++;
            end else if (m_state == 5 && mem_ack) begin
                m_state = 0;
            end else if (m_state == 0 && m_ring && m_intr) begin
                for (int k = 1; k <= NS; k++) begin
                    int c;
                    c = (m_last + k) % NS;
                    if (m_state == 0 && sv_old[c]) begin
                        m_vec = m_slot[c]; m_sv[c] = 0; m_last = c; m_state = 1;
                    end
                end
            end
            for (int s = 0; s < NS; s++)
                if (src_valid[s] && !sv_old[s]) begin m_sv[s] = 1; m_slot[s] = src_event[s*EW +: EW]; end
            if (reg_we) begin
                case (reg_addr)
                    3'd0: begin
                        if (reg_wdata[31] && !set_now) m_flag = 0;
                        m_ring = reg_wdata[0]; m_intr = reg_wdata[1];
                        m_ovf = reg_wdata[2]; m_wb = reg_wdata[3];
                        m_size = int'(reg_wdata[8:4]);
                    end
                    3'd1: m_base = reg_wdata;
                    3'd2: m_rptr = int'(reg_wdata[15:0]) & 32'hFFF0;
                    3'd3: if (!m_ring) begin m_wptr = int'(reg_wdata[15:0]) & 32'hFFF0; m_flag = 0; end
                    3'd4: m_wblo = reg_wdata;
                    3'd5: m_wbhi = reg_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic raise(input logic [NS-1:0] which, input int n);
        @(negedge clk);
        for (int s = 0; s < NS; s++)
            if (which[s]) begin
                src_valid[s] = 1'b1;
                src_event[s*EW +: EW] = mk_event(s, n + s);
            end
        @(negedge clk);
        src_valid = '0;
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while ((m_state != 0 || m_sv[0] || m_sv[1] || m_sv[2] || m_sv[3]) && guard < 5000);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset values, R4 idle after reset, R9 not busy
        rd(3'd0, 32'h0, "R10 CTRL reset");
        rd(3'd3, 32'h0, "R10 WPTR reset");
        rd(3'd6, 32'h2, "R9 STATUS reset");
        check(host_irq == 1'b0, "R4 irq after reset", 64'(host_irq), 64'h0);

        // Configuration: 64-byte ring (S=4), all features on.
        wr(3'd1, 32'h0012_3456);
        wr(3'd4, 32'h0000_1007);
        wr(3'd5, 32'h0000_01AB);
        rd(3'd5, 32'h0000_00AB, "R6 WBHI keeps 8 bits");
        rd(3'd4, 32'h0000_1004, "R10 WBLO word aligned");
        wr(3'd0, 32'h0000_004F);
        rd(3'd0, 32'h0000_004F, "R10 CTRL readback");

        // Single vector: R1 packing, R3 pointer step.
        raise(4'b0010, 1);
        wait_idle();
        rd(3'd3, 32'h10, "R3 WPTR after one vector");
        rd(3'd6, 32'h0, "R9 idle not busy, R4 pointers differ");
        wr(3'd2, 32'h10);
        rd(3'd6, 32'h2, "R4 pointers equal after host read");

        // All sources at once: R7 rotation; fourth vector overflows (R5).
        raise(4'b1111, 10);
        wait_idle();
        rd(3'd3, 32'h11, "R5 overflow flag in WPTR bit 0");
        check(host_irq == 1'b1, "R4 irq held by overflow", 64'(host_irq), 64'h1);
        wr(3'd0, 32'h8000_004F);
        rd(3'd3, 32'h10, "R5 flag cleared by CTRL bit 31");
        rd(3'd0, 32'h0000_004F, "R10 CTRL bit 31 reads 0");

        // Busy while in flight (R9).
        raise(4'b0100, 20);
        rd(3'd6, 32'h3, "R9 busy during vector");
        wait_idle();
        wr(3'd2, 32'h20);

        // Writeback off (R6): model rejects any fifth write.
        wr(3'd0, 32'h0000_0047);
        raise(4'b0001, 30);
        wait_idle();
        rd(3'd3, 32'h30, "R6 vector without writeback");

        // Ring disabled (R8): no start, pointer loads.
        wr(3'd0, 32'h0000_0046);
        raise(4'b1000, 40);
        repeat (10) @(negedge clk);
        check(src_ready[3] == 1'b0, "R8 slot held while disabled", 64'(src_ready[3]), 64'h0);
        check(mem_req == 1'b0, "R8 no write while disabled", 64'(mem_req), 64'h0);
        wr(3'd3, 32'h0);
        rd(3'd3, 32'h0, "R8 WPTR load while disabled");
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h0000_0047);
        wait_idle();
        rd(3'd3, 32'h10, "R8 pending vector after enable");
        wr(3'd3, 32'h30);
        rd(3'd3, 32'h10, "R8 WPTR write ignored while enabled");

        // Interrupt enable off (R4, R8).
        wr(3'd0, 32'h0000_0045);
        raise(4'b0010, 50);
        repeat (10) @(negedge clk);
        check(host_irq == 1'b0, "R4 irq masked", 64'(host_irq), 64'h0);
        check(src_ready[1] == 1'b0, "R8 no start without interrupt enable", 64'(src_ready[1]), 64'h0);
        wr(3'd0, 32'h0000_0047);
        wait_idle();

        // One-vector ring (S=2), detection off: wrap to zero, no flag (R3, R5).
        wr(3'd0, 32'h0000_002B);
        wr(3'd2, 32'h0);
        raise(4'b1111, 60);
        wait_idle();
        rd(3'd3, 32'h0, "R3 wrap in 16-byte ring, R5 no flag");

        // Random traffic with stalled acks and moving read pointer.
        wr(3'd0, 32'h0000_005F);
        ack_rand = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            src_valid = rng[NS-1:0] & rng[NS+3:4];
            for (int s = 0; s < NS; s++) src_event[s*EW +: EW] = mk_event(s, 100 + i);
            reg_we    = (i % 37 == 5);
            reg_addr  = 3'd2;
            reg_wdata = 32'(i * 16);
        end
        @(negedge clk);
        src_valid = '0; reg_we = 1'b0;
        wait_idle();
        ack_rand = 1'b0;
        rd(3'd6, {30'b0, ((m_rptr & mmask()) == m_wptr) ? 1'b1 : 1'b0, 1'b0}, "R9 idle after traffic");
        finish_run();
    end
endmodule